// File: doc/BRIEF.md
# Peripheral Reset Line Register Bank

This block holds one register bit per peripheral and drives the bit out as an active-low reset line. A line at 0 keeps its peripheral in reset, and a line at 1 lets it run. Software reaches the bank over a plain 32-bit register bus. Two write-only command offsets change the lines. One offset releases every line whose written bit is 1. The other offset holds every line whose written bit is 1 in reset. A bit written as 0 leaves its line as it was. Because of this, no read-modify-write sequence is ever needed to touch a single peripheral.

A third offset reports the level of each line, passed through a two-flop synchronizer. This suits lines that are consumed in another clock domain. When the parameter `STATUS_EXT` is 1, the synchronizer samples the `level_in` input instead of the bank's own outputs, so an externally observed line level can be reported. To pulse a reset, software holds the line, waits at least a microsecond, releases it, and waits again. Software provides these waits; the block does not time them. When several clusters exist, a cluster's lines are numbered globally as cluster index times lines per cluster plus bit position. That decoding sits outside this block.

Top module: `soft_reset_bank`

## Requirements
- R1: While `rst_n` is sampled low, every `prst_n` bit n takes the value of bit n of `RELEASE_MASK` (0 means held in reset). This applies both at power-up and on any later reset.
- R2: A write to offset 0x01C drives low, at the next clock edge, every line whose `reg_wdata` bit is 1. Lines whose bit is 0 keep their level.
- R3: A write to offset 0x018 drives high, at the next clock edge, every line whose `reg_wdata` bit is 1. Lines whose bit is 0 keep their level.
- R4: With `STATUS_EXT` = 0, a read of offset 0x020 returns the line levels through two flops. After the edge that changes a line, the new level appears on `reg_rdata` only after the second following edge.
- R5: A read of offset 0x018 or 0x01C returns the present `prst_n` levels, with no lag.
- R6: `reg_rdata` is 0 when `reg_re` is low or the offset is not 0x018, 0x01C or 0x020. A write to any other offset, including 0x020, changes no line.
- R7: Write data bits at or above `NUM_LINES` are ignored, and the matching `reg_rdata` bits always read 0.
- R8: Writes on consecutive cycles each take effect at their own edge. A hold followed directly by a release of the same line leaves it released.
- R9: With `STATUS_EXT` = 1, offset 0x020 returns `level_in` delayed by two flops, and the bank's own outputs are not reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bank and the synchronizer |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_we | input | 1 | Write strobe, one access per cycle |
| reg_wdata | input | 32 | Write data, one bit per line |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_re` |
| level_in | input | NUM_LINES | Observed line levels, used when `STATUS_EXT` = 1 |
| prst_n | output | NUM_LINES | Active-low reset lines, one per peripheral |

## Verification
The assertions assume that `reg_we` and `reg_re` are known values after reset. They also assume a single address per cycle, so a release and a hold of the same cycle cannot collide. The bench meets these assumptions by driving the bus only on falling edges, from one task at a time, and by returning both strobes low between accesses. The status lag check assumes that two reset-free cycles have passed. The bench therefore waits two cycles after every write before it reads the status offset, except in the directed test that measures the lag edge by edge.

// File: rtl/rstbank_pkg.sv
// Shared definitions for the reset line bank: register offsets and the
// decoded access kind. Offsets are byte addresses on the register bus.
package rstbank_pkg;

    localparam int unsigned OFF_RELEASE = 'h018;  // write ones: release lines
    localparam int unsigned OFF_HOLD    = 'h01C;  // write ones: hold lines in reset
    localparam int unsigned OFF_LEVEL   = 'h020;  // read: synchronized line level

    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_RELEASE = 2'd1,
        ACC_HOLD    = 2'd2,
        ACC_LEVEL   = 2'd3
    } acc_e;

endpackage

// File: rtl/rstbank_decode.sv
// Address decoder: maps a bus offset to one access kind.
// Assumes ADDR_W is wide enough (>= 6) to hold every offset.
module rstbank_decode
    import rstbank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              acc
);

    // Full-width compare so that aliases of the offsets stay unmapped.
    always_comb begin
        if (addr == ADDR_W'(OFF_RELEASE))    acc = ACC_RELEASE;
        else if (addr == ADDR_W'(OFF_HOLD))  acc = ACC_HOLD;
        else if (addr == ADDR_W'(OFF_LEVEL)) acc = ACC_LEVEL;
        else                                 acc = ACC_NONE;
    end

endmodule

// File: rtl/rstbank_lines.sv
// Line state register: one flop per reset line, updated by write-one-to-
// release and write-one-to-hold commands. Assumes at most one command per
// cycle (the decoder never raises both strobes together).
module rstbank_lines #(
    parameter int          NUM_LINES    = 32,
    parameter logic [31:0] RELEASE_MASK = 32'h0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 do_release,
    input  logic                 do_hold,
    input  logic [NUM_LINES-1:0] bits,
    output logic [NUM_LINES-1:0] lines_q
);

    localparam logic [NUM_LINES-1:0] INIT = RELEASE_MASK[NUM_LINES-1:0];

    // Apply the command of this cycle, or load the reset pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)          lines_q <= INIT;
        else if (do_release) lines_q <= lines_q | bits;
        else if (do_hold)    lines_q <= lines_q & ~bits;
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_hold |=> (((lines_q & $past(bits)) == '0) &&
                     ((lines_q & ~$past(bits)) == ($past(lines_q) & ~$past(bits)))));

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_release |=> (((lines_q & $past(bits)) == $past(bits)) &&
                        ((lines_q & ~$past(bits)) == ($past(lines_q) & ~$past(bits)))));

    assert_no_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_release && !do_hold) |=> $stable(lines_q));

endmodule

// File: rtl/rstbank_sync.sv
// Two-flop synchronizer for the level report. Each bit is sampled on its own,
// so it assumes every line is a quasi-static level, not a multi-bit code.
module rstbank_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] meta_q;

    // Shift the sampled level through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            dout   <= '0;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end

endmodule

// File: rtl/soft_reset_bank.sv
// Reset line register bank top: decodes the bus and drives NUM_LINES active-low
// reset lines. It reports the line levels through a synchronizer, and returns
// read data in the same cycle as the read strobe. Assumes 1 <= NUM_LINES <= 32.
module soft_reset_bank
    import rstbank_pkg::*;
#(
    parameter int          NUM_LINES    = 32,
    parameter int          ADDR_W       = 12,
    parameter logic [31:0] RELEASE_MASK = 32'h0,
    parameter bit          STATUS_EXT   = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [31:0]          reg_wdata,
    input  logic                 reg_re,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] level_in,
    output logic [NUM_LINES-1:0] prst_n
);

    acc_e                 acc;
    logic [NUM_LINES-1:0] lines;
    logic [NUM_LINES-1:0] lvl_src;
    logic [NUM_LINES-1:0] lvl_sync;

    rstbank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .acc  (acc)
    );

    rstbank_lines #(.NUM_LINES(NUM_LINES), .RELEASE_MASK(RELEASE_MASK)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_release (reg_we && (acc == ACC_RELEASE)),
        .do_hold    (reg_we && (acc == ACC_HOLD)),
        .bits       (reg_wdata[NUM_LINES-1:0]),
        .lines_q    (lines)
    );

    // Pick the level source for the report.
    generate
        if (STATUS_EXT) begin : g_ext
            assign lvl_src = level_in;
        end else begin : g_own
            logic unused_level;
            assign unused_level = ^level_in;
            assign lvl_src      = lines;
        end
    endgenerate

    rstbank_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lvl_src),
        .dout  (lvl_sync)
    );

    assign prst_n = lines;

    // Read multiplexer: zero outside a mapped read, upper bits always zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_re) begin
            case (acc)
                ACC_RELEASE, ACC_HOLD: reg_rdata[NUM_LINES-1:0] = lines;
                ACC_LEVEL:             reg_rdata[NUM_LINES-1:0] = lvl_sync;
                default:               reg_rdata = '0;
            endcase
        end
    end

    assert_cmd_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && (acc == ACC_RELEASE || acc == ACC_HOLD))
            |-> (reg_rdata == 32'(prst_n)));

    generate
        if (!STATUS_EXT) begin : g_lag_chk
            assert_level_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (lvl_sync == $past(prst_n, 2)));
        end
    endgenerate

endmodule

// File: tb/soft_reset_bank_tb.sv
`timescale 1ns/1ps
module soft_reset_bank_tb_top;

    localparam int          N    = 12;
    localparam logic [31:0] MASK = 32'h0000_0005;
    localparam logic [11:0] A_REL = 12'h018;
    localparam logic [11:0] A_HLD = 12'h01C;
    localparam logic [11:0] A_LVL = 12'h020;
    localparam logic [1:0]  K_WR = 2'd1;
    localparam logic [1:0]  K_RD = 2'd2;
    localparam int          NV = 13;

    // {kind, addr, data, expected}: writes expect prst_n, reads expect rdata.
    localparam logic [77:0] VEC [NV] = '{
        {K_WR, A_HLD, 32'h0000_0FFF, 32'h0000_0000},  // R2 hold all
        {K_WR, A_REL, 32'h0000_00F0, 32'h0000_00F0},  // R3 release some
        {K_RD, A_LVL, 32'h0,         32'h0000_00F0},  // R4 settled level
        {K_RD, A_REL, 32'h0,         32'h0000_00F0},  // R5
        {K_RD, A_HLD, 32'h0,         32'h0000_00F0},  // R5
        {K_WR, A_HLD, 32'h0000_0030, 32'h0000_00C0},  // R2 partial
        {K_WR, A_REL, 32'hFFFF_F001, 32'h0000_00C1},  // R7 high bits ignored
        {K_RD, A_REL, 32'h0,         32'h0000_00C1},  // R7 upper read zero
        {K_WR, 12'h024, 32'h0000_0FFF, 32'h0000_00C1}, // R6 unmapped write
        {K_WR, 12'h000, 32'h0000_0FFF, 32'h0000_00C1}, // R6 unmapped write
        {K_WR, A_LVL, 32'h0000_0FFF, 32'h0000_00C1},  // R6 write to level
        {K_RD, 12'h024, 32'h0,       32'h0000_0000},  // R6 unmapped read
        {K_RD, A_LVL, 32'h0,         32'h0000_00C1}   // R4
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_re = 1'b0;
    logic [31:0]   rdata, rdata_ext;
    logic [N-1:0]  level_in = 12'hA5A;
    logic [N-1:0]  prst_n, prst_n_ext;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    soft_reset_bank #(.NUM_LINES(N), .ADDR_W(12), .RELEASE_MASK(MASK), .STATUS_EXT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(rdata),
        .level_in(level_in), .prst_n(prst_n)
    );

    soft_reset_bank #(.NUM_LINES(N), .ADDR_W(12), .RELEASE_MASK(MASK), .STATUS_EXT(1'b1)) dut_ext_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(rdata_ext),
        .level_in(level_in), .prst_n(prst_n_ext)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 d = rdata;
        reg_re = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        // R1: reset pattern while reset is held
        repeat (3) @(negedge clk);
        check("R1 reset lines", 32'(prst_n), MASK);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R4 / R9: level report from own lines and from level_in
        reg_addr = A_LVL; reg_re = 1'b1;
        #1;
        check("R4 level after reset", rdata, MASK);
        check("R9 external level", rdata_ext, 32'h0000_0A5A);
        reg_re = 1'b0;
        level_in = 12'h3C3;
        repeat (2) @(negedge clk);
        bus_read(A_LVL, rd);
        check("R9 external level change", rdata_ext, 32'h0000_03C3);
        check("R9 own bank ignores level_in", rd, MASK);
        // R6: read strobe low gives zero
        reg_addr = A_REL;
        #1 check("R6 no read strobe", rdata, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [77:0] v;
            v = VEC[i];
            if (v[77:76] == K_WR) begin
                bus_write(v[75:64], v[63:32]);
                check($sformatf("R2/R3/R6/R7 vector %0d lines", i), 32'(prst_n), v[31:0]);
                repeat (2) @(negedge clk);
            end else begin
                bus_read(v[75:64], rd);
                check($sformatf("R4/R5/R6/R7 vector %0d read", i), rd, v[31:0]);
            end
        end

        // R4: edge-by-edge lag of the level report (lines 0x0C1 -> 0x041)
        @(negedge clk);
        reg_addr = A_HLD; reg_wdata = 32'h080; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = A_LVL; reg_re = 1'b1;
        #1 check("R4 lag after 0 edges", rdata, 32'h0C1);
        check("R2 bit 7 held", 32'(prst_n), 32'h041);
        @(negedge clk);
        #1 check("R4 lag after 1 edge", rdata, 32'h0C1);
        @(negedge clk);
        #1 check("R4 level after 2 edges", rdata, 32'h041);
        reg_re = 1'b0;

        // R8: hold then release of line 0 on consecutive cycles
        @(negedge clk);
        reg_addr = A_HLD; reg_wdata = 32'h001; reg_we = 1'b1;
        @(negedge clk);
        check("R8 hold took effect", 32'(prst_n), 32'h040);
        reg_addr = A_REL;
        @(negedge clk);
        reg_we = 1'b0;
        check("R8 later release wins", 32'(prst_n), 32'h041);

        // R1: reset in mid-run restores the pattern
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", 32'(prst_n), MASK);
        rst_n = 1'b1;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule